// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block turns single bus-cycle requests into the pin waveform of an asynchronous NAND flash device. A request names one of four cycle kinds (command byte, address byte, data read, data write), the chip to address and, for writes, the value to drive. The block asserts the chip enable and the latch-enable line that the cycle needs. It then steps through programmable phases: setup, strobe-low, hold and, for cycles that drive the bus, an extra bus-release interval. When the cycle ends, the block accepts the next request.

Command and address cycles take their phase lengths from one timing set, and data cycles take theirs from a second set. A read that directly follows a command or address cycle waits a separate programmable delay before its setup phase, so the latch-to-read-strobe spacing is met. An optional stall freezes the strobe phase while the device's ready/busy line is low. Read data is sampled as the read strobe rises and is returned with a single-cycle valid flag. The bus width is 8 or 16 bits, and any cycle can narrow itself to 8 bits.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, req_ready is 0 and the pins are idle: all nand_ce_n high, nand_we_n and nand_re_n high, nand_cle, nand_ale, nand_dq_oe and rsp_valid low. Both timing sets reset to 0x0A in every field, both latch-to-read delays reset to 15, and the bank enable, wait enable and wide mode reset to 0.
- R2: req_ready is 1 only when the bank is enabled and no cycle is in progress. A request presented while the bank is disabled is dropped: it produces no pin activity, and it does not start later when the bank is enabled.
- R3: A cycle accepted at a clock edge holds the selected chip enable low for every clock of the cycle. It spends `setup` clocks with the strobe high, then `wait` clocks with the strobe low (nand_we_n for command, address and write cycles, nand_re_n for reads), then `hold` clocks with the strobe high. A setup, wait or hold count of 0 behaves as 1, and only one strobe is ever low.
- R4: Timing words are packed as setup in bits [7:0], wait in [15:8], hold in [23:16] and release in [31:24]. Command and address cycles use tim_ctl, and data read and write cycles use tim_data. Both are loaded with tim_load, together with the two delays.
- R5: Cycles that drive the bus (command, address, write) keep nand_dq_oe high from the first setup clock to the end of the cycle. After the hold phase they add `release` clocks with the chip enable still low, and a count of 0 adds none. Reads never drive the bus.
- R6: req_kind encodes 0 = command, 1 = address, 2 = data read, 3 = data write. nand_cle is high for every clock of a command cycle and nand_ale for every clock of an address cycle. Neither is high in any other cycle.
- R7: Bit req_cs of nand_ce_n is the only chip enable driven low during the cycle.
- R8: A read whose preceding cycle was a command cycle inserts tim_cle_re extra clocks before its setup phase, with the chip enable low and the strobe high. After an address cycle it inserts tim_ale_re clocks. After reset, or after any data cycle, it inserts none.
- R9: While wait mode is enabled (ctl_wait_en loaded through ctl_load), each clock edge in the strobe phase that sees nand_rb low adds one clock to the strobe. With wait mode off, nand_rb has no effect.
- R10: For a read, rsp_rdata holds nand_dq_i as sampled at the last strobe-low clock. rsp_valid is high for exactly one clock, the first hold clock, which is the clock in which nand_re_n has just risen.
- R11: Data cycles use all 16 bits when wide mode is on and req_narrow is 0. Otherwise they use only bits [7:0], and the upper byte reads and drives as zero. Command and address cycles always use 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_load | input | 1 | Loads the three control bits below |
| ctl_bank_en | input | 1 | Bank enable value |
| ctl_wait_en | input | 1 | Stall-on-busy enable value |
| ctl_wide | input | 1 | 16-bit data mode value |
| tim_load | input | 1 | Loads both timing sets and both delays |
| tim_data | input | 32 | Timing set for data cycles |
| tim_ctl | input | 32 | Timing set for command/address cycles |
| tim_cle_re | input | 4 | Command-to-read delay in clocks |
| tim_ale_re | input | 4 | Address-to-read delay in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_kind | input | 2 | Cycle kind |
| req_cs | input | 1 | Target chip |
| req_narrow | input | 1 | Force 8-bit width for this cycle |
| req_wdata | input | 16 | Byte or word to drive |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Captured read data |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 16 | Bus output value |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 16 | Bus input value |
| nand_rb | input | 1 | Ready/busy, low when busy |

## Verification
A corrupted phase or counter state appears in the same cycle as a wrong number of strobe-low or chip-enable clocks. It can also appear as a strobe falling while the other strobe is low, or as a bus drive during a read. Each of these is visible at the next clock edge. A stale previous-cycle kind first shows on the following read, as a missing or misplaced delay before nand_re_n falls. A wrong width or capture edge shows in the one rsp_valid clock, as a masked or early byte. The bench sweeps all kinds against small timing values and counts each phase in clocks at the pins.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   localparam int TCNT_W = 8;

   typedef enum logic [1:0] {
      KIND_CMD  = 2'd0,
      KIND_ADDR = 2'd1,
      KIND_RD   = 2'd2,
      KIND_WR   = 2'd3
   } kind_e;

   typedef enum logic [2:0] {
      PH_IDLE, PH_DLY, PH_SETUP, PH_STROBE, PH_HOLD, PH_HIZ
   } phase_e;

   typedef struct packed {
      logic [TCNT_W-1:0] hiz;
      logic [TCNT_W-1:0] hold;
      logic [TCNT_W-1:0] strobe;
      logic [TCNT_W-1:0] setup;
   } tset_t;

   localparam logic [TCNT_W-1:0] TFIELD_RST = TCNT_W'(8'h0A);
endpackage

// File: rtl/nand_seq_cfg.sv
module nand_seq_cfg
   import nand_seq_pkg::*;
#(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_load,
   input  logic             ctl_bank_en,
   input  logic             ctl_wait_en,
   input  logic             ctl_wide,
   input  logic             tim_load,
   input  tset_t            tim_data,
   input  tset_t            tim_ctl,
   input  logic [DLY_W-1:0] tim_cle_re,
   input  logic [DLY_W-1:0] tim_ale_re,
   output logic             bank_q,
   output logic             wait_q,
   output logic             wide_q,
   output tset_t            data_q,
   output tset_t            ctl_q,
   output logic [DLY_W-1:0] cle_re_q,
   output logic [DLY_W-1:0] ale_re_q
);
   localparam tset_t SET_RST = '{hiz: TFIELD_RST, hold: TFIELD_RST,
                                 strobe: TFIELD_RST, setup: TFIELD_RST};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= 1'b0;
         wait_q <= 1'b0;
         wide_q <= 1'b0;
      end else if (ctl_load) begin
         bank_q <= ctl_bank_en;
         wait_q <= ctl_wait_en;
         wide_q <= ctl_wide;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= SET_RST;
         ctl_q    <= SET_RST;
         cle_re_q <= '1;
         ale_re_q <= '1;
      end else if (tim_load) begin
         data_q   <= tim_data;
         ctl_q    <= tim_ctl;
         cle_re_q <= tim_cle_re;
         ale_re_q <= tim_ale_re;
      end
   end
endmodule

// File: rtl/nand_phase_ctr.sv
module nand_phase_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         freeze,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (!freeze && cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
   import nand_seq_pkg::*;
#(
   parameter int CS_W  = 1,
   parameter int DQ_W  = 16,
   parameter int DLY_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_en,
   input  logic              wait_en,
   input  logic              nand_rb,
   input  logic              req_valid,
   input  kind_e             req_kind,
   input  logic [CS_W-1:0]   req_cs,
   input  logic              req_narrow,
   input  logic [DQ_W-1:0]   req_wdata,
   input  tset_t             data_set,
   input  tset_t             ctl_set,
   input  logic [DLY_W-1:0]  cle_re,
   input  logic [DLY_W-1:0]  ale_re,
   input  logic              ctr_done,
   output logic              req_ready,
   output phase_e            phase_q,
   output kind_e             kind_q,
   output logic [CS_W-1:0]   cs_q,
   output logic              narrow_q,
   output logic [DQ_W-1:0]   wdata_q,
   output logic              ctr_load,
   output logic [TCNT_W-1:0] ctr_val,
   output logic              ctr_freeze,
   output logic              strobe_end
);
   kind_e             last_q;
   kind_e             eff_kind;
   tset_t             tset;
   phase_e            ph_nxt;
   logic              accept;
   logic              advance;
   logic              drives_bus;
   logic [TCNT_W-1:0] dly;
   logic [TCNT_W-1:0] len;

   function automatic logic [TCNT_W-1:0] at_least_one(input logic [TCNT_W-1:0] v);
      return (v == '0) ? TCNT_W'(1) : v;
   endfunction

   assign req_ready  = bank_en && (phase_q == PH_IDLE);
   assign accept     = req_valid && req_ready;
   assign ctr_freeze = (phase_q == PH_STROBE) && wait_en && !nand_rb;
   assign advance    = (phase_q != PH_IDLE) && ctr_done && !ctr_freeze;
   assign strobe_end = (phase_q == PH_STROBE) && advance;

   assign eff_kind   = (phase_q == PH_IDLE) ? req_kind : kind_q;
   assign tset       = (eff_kind == KIND_RD || eff_kind == KIND_WR) ? data_set : ctl_set;
   assign drives_bus = (eff_kind != KIND_RD);

   always_comb begin
      dly = '0;
      if (eff_kind == KIND_RD) begin
         if (last_q == KIND_CMD)
            dly = TCNT_W'(cle_re);
         else if (last_q == KIND_ADDR)
            dly = TCNT_W'(ale_re);
      end
   end

   always_comb begin
      ph_nxt = phase_q;
      if (accept) begin
         ph_nxt = (dly != '0) ? PH_DLY : PH_SETUP;
      end else if (advance) begin
         case (phase_q)
            PH_DLY:    ph_nxt = PH_SETUP;
            PH_SETUP:  ph_nxt = PH_STROBE;
            PH_STROBE: ph_nxt = PH_HOLD;
            PH_HOLD:   ph_nxt = (drives_bus && tset.hiz != '0) ? PH_HIZ : PH_IDLE;
            default:   ph_nxt = PH_IDLE;
         endcase
      end
   end

   always_comb begin
      case (ph_nxt)
         PH_DLY:    len = dly;
         PH_SETUP:  len = at_least_one(tset.setup);
         PH_STROBE: len = at_least_one(tset.strobe);
         PH_HOLD:   len = at_least_one(tset.hold);
         PH_HIZ:    len = tset.hiz;
         default:   len = TCNT_W'(1);
      endcase
   end

   assign ctr_load = (ph_nxt != phase_q);
   assign ctr_val  = len - TCNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         kind_q   <= KIND_RD;
         last_q   <= KIND_RD;
         cs_q     <= '0;
         narrow_q <= 1'b0;
         wdata_q  <= '0;
      end else begin
         phase_q <= ph_nxt;
         if (accept) begin
            kind_q   <= req_kind;
            cs_q     <= req_cs;
            narrow_q <= req_narrow;
            wdata_q  <= req_wdata;
         end
         if (advance && ph_nxt == PH_IDLE)
            last_q <= kind_q;
      end
   end
endmodule

// File: rtl/nand_pin_drv.sv
module nand_pin_drv
   import nand_seq_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int CS_W   = 1,
   parameter int DQ_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase_q,
   input  kind_e             kind_q,
   input  logic [CS_W-1:0]   cs_q,
   input  logic              narrow_q,
   input  logic              wide_q,
   input  logic [DQ_W-1:0]   wdata_q,
   input  logic              strobe_end,
   input  logic [DQ_W-1:0]   dq_i,
   output logic [NUM_CS-1:0] ce_n,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [DQ_W-1:0]   dq_o,
   output logic              dq_oe,
   output logic              rsp_valid,
   output logic [DQ_W-1:0]   rsp_rdata
);
   localparam logic [DQ_W-1:0] BYTE_MASK = DQ_W'(8'hFF);

   logic            active;
   logic            is_read;
   logic            is_data;
   logic            wide_eff;
   logic [DQ_W-1:0] mask;

   assign active   = (phase_q != PH_IDLE);
   assign is_read  = (kind_q == KIND_RD);
   assign is_data  = (kind_q == KIND_RD) || (kind_q == KIND_WR);
   assign wide_eff = wide_q && !narrow_q && is_data;

   generate
      if (DQ_W > 8) begin : g_dq_wide
         assign mask = wide_eff ? '1 : BYTE_MASK;
      end else begin : g_dq_byte
         assign mask = '1;
      end

      for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
         assign ce_n[i] = !(active && cs_q == CS_W'(i));
      end
   endgenerate

   assign cle   = active && (kind_q == KIND_CMD);
   assign ale   = active && (kind_q == KIND_ADDR);
   assign we_n  = !((phase_q == PH_STROBE) && !is_read);
   assign re_n  = !((phase_q == PH_STROBE) && is_read);
   assign dq_oe = active && !is_read;
   assign dq_o  = wdata_q & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= strobe_end && is_read;
         if (strobe_end && is_read)
            rsp_rdata <= dq_i & mask;
      end
   end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nand_seq_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int DQ_W   = 16,
   parameter int DLY_W  = 4,
   localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int TSET_W = 4 * TCNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_load,
   input  logic              ctl_bank_en,
   input  logic              ctl_wait_en,
   input  logic              ctl_wide,
   input  logic              tim_load,
   input  logic [TSET_W-1:0] tim_data,
   input  logic [TSET_W-1:0] tim_ctl,
   input  logic [DLY_W-1:0]  tim_cle_re,
   input  logic [DLY_W-1:0]  tim_ale_re,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [CS_W-1:0]   req_cs,
   input  logic              req_narrow,
   input  logic [DQ_W-1:0]   req_wdata,
   output logic              rsp_valid,
   output logic [DQ_W-1:0]   rsp_rdata,
   output logic [NUM_CS-1:0] nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [DQ_W-1:0]   nand_dq_o,
   output logic              nand_dq_oe,
   input  logic [DQ_W-1:0]   nand_dq_i,
   input  logic              nand_rb
);
   generate
      if (DQ_W != 8 && DQ_W != 16) begin : g_bad_dq
         $error("nand_cycle_seq: DQ_W must be 8 or 16");
      end
      if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_cs
         $error("nand_cycle_seq: NUM_CS must be 1 to 8");
      end
      if (DLY_W < 1 || DLY_W > TCNT_W) begin : g_bad_dly
         $error("nand_cycle_seq: DLY_W must be 1 to TCNT_W");
      end
   endgenerate

   logic              bank_q, wait_q, wide_q;
   tset_t             data_q, ctl_q;
   logic [DLY_W-1:0]  cle_re_q, ale_re_q;
   phase_e            phase_q;
   kind_e             kind_q;
   logic [CS_W-1:0]   cs_q;
   logic              narrow_q;
   logic [DQ_W-1:0]   wdata_q;
   logic              ctr_load, ctr_freeze, ctr_done, strobe_end;
   logic [TCNT_W-1:0] ctr_val;

   nand_seq_cfg #(.DLY_W(DLY_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_load   (ctl_load),
      .ctl_bank_en(ctl_bank_en),
      .ctl_wait_en(ctl_wait_en),
      .ctl_wide   (ctl_wide),
      .tim_load   (tim_load),
      .tim_data   (tset_t'(tim_data)),
      .tim_ctl    (tset_t'(tim_ctl)),
      .tim_cle_re (tim_cle_re),
      .tim_ale_re (tim_ale_re),
      .bank_q     (bank_q),
      .wait_q     (wait_q),
      .wide_q     (wide_q),
      .data_q     (data_q),
      .ctl_q      (ctl_q),
      .cle_re_q   (cle_re_q),
      .ale_re_q   (ale_re_q)
   );

   nand_seq_fsm #(.CS_W(CS_W), .DQ_W(DQ_W), .DLY_W(DLY_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_en   (bank_q),
      .wait_en   (wait_q),
      .nand_rb   (nand_rb),
      .req_valid (req_valid),
      .req_kind  (kind_e'(req_kind)),
      .req_cs    (req_cs),
      .req_narrow(req_narrow),
      .req_wdata (req_wdata),
      .data_set  (data_q),
      .ctl_set   (ctl_q),
      .cle_re    (cle_re_q),
      .ale_re    (ale_re_q),
      .ctr_done  (ctr_done),
      .req_ready (req_ready),
      .phase_q   (phase_q),
      .kind_q    (kind_q),
      .cs_q      (cs_q),
      .narrow_q  (narrow_q),
      .wdata_q   (wdata_q),
      .ctr_load  (ctr_load),
      .ctr_val   (ctr_val),
      .ctr_freeze(ctr_freeze),
      .strobe_end(strobe_end)
   );

   nand_phase_ctr #(.W(TCNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ctr_load),
      .load_val(ctr_val),
      .freeze  (ctr_freeze),
      .done    (ctr_done)
   );

   nand_pin_drv #(.NUM_CS(NUM_CS), .CS_W(CS_W), .DQ_W(DQ_W)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_q   (phase_q),
      .kind_q    (kind_q),
      .cs_q      (cs_q),
      .narrow_q  (narrow_q),
      .wide_q    (wide_q),
      .wdata_q   (wdata_q),
      .strobe_end(strobe_end),
      .dq_i      (nand_dq_i),
      .ce_n      (nand_ce_n),
      .cle       (nand_cle),
      .ale       (nand_ale),
      .we_n      (nand_we_n),
      .re_n      (nand_re_n),
      .dq_o      (nand_dq_o),
      .dq_oe     (nand_dq_oe),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
   parameter int NUM_CS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bank_en,
   input logic              wait_en,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [NUM_CS-1:0] ce_n,
   input logic              cle,
   input logic              ale,
   input logic              we_n,
   input logic              re_n,
   input logic              dq_oe,
   input logic              rb
);
   AST_READY_NEEDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en |-> !req_ready); // R2
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n)); // R3
   AST_STROBE_HAS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> !(&ce_n)); // R3
   AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !dq_oe); // R5
   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale)); // R6
   AST_CE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ce_n)); // R7
   AST_WE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_en && !rb && !we_n) |=> !we_n); // R9
   AST_RE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_en && !rb && !re_n) |=> !re_n); // R9
   AST_RSP_ON_RE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(re_n)); // R10
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
endmodule

bind nand_cycle_seq nand_seq_chk #(.NUM_CS(NUM_CS)) u_seq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bank_en  (bank_q),
   .wait_en  (wait_q),
   .req_ready(req_ready),
   .rsp_valid(rsp_valid),
   .ce_n     (nand_ce_n),
   .cle      (nand_cle),
   .ale      (nand_ale),
   .we_n     (nand_we_n),
   .re_n     (nand_re_n),
   .dq_oe    (nand_dq_oe),
   .rb       (nand_rb)
);

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_load = 1'b0, ctl_bank_en = 1'b0, ctl_wait_en = 1'b0, ctl_wide = 1'b0;
   logic        tim_load = 1'b0;
   logic [31:0] tim_data = '0, tim_ctl = '0;
   logic [3:0]  tim_cle_re = '0, tim_ale_re = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = '0;
   logic [0:0]  req_cs = '0;
   logic        req_narrow = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [1:0]  nand_ce_n;
   logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [15:0] nand_dq_o;
   logic [15:0] nand_dq_i = '0;
   logic        nand_rb = 1'b1;

   int n_chk = 0;
   int n_bad = 0;

   // bench model of the programmed state
   int m_data[4];
   int m_ctl[4];
   int m_cle = 15, m_ale = 15, m_last = 2;
   bit m_wait = 0, m_wide = 0;

   always #5 clk = ~clk;

   nand_cycle_seq i_nand_cycle_seq (
      .clk(clk), .rst_n(rst_n),
      .ctl_load(ctl_load), .ctl_bank_en(ctl_bank_en), .ctl_wait_en(ctl_wait_en), .ctl_wide(ctl_wide),
      .tim_load(tim_load), .tim_data(tim_data), .tim_ctl(tim_ctl),
      .tim_cle_re(tim_cle_re), .tim_ale_re(tim_ale_re),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_cs(req_cs),
      .req_narrow(req_narrow), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_ctl(input bit bank, input bit wt, input bit wide);
      @(negedge clk);
      ctl_load = 1'b1; ctl_bank_en = bank; ctl_wait_en = wt; ctl_wide = wide;
      @(negedge clk);
      ctl_load = 1'b0;
      m_wait = wt; m_wide = wide;
   endtask

   task automatic set_tim(input int ds, input int dw, input int dh, input int dz,
                          input int cs_, input int cw, input int ch, input int cz,
                          input int cle_d, input int ale_d);
      @(negedge clk);
      tim_load = 1'b1;
      tim_data = {8'(dz), 8'(dh), 8'(dw), 8'(ds)};
      tim_ctl  = {8'(cz), 8'(ch), 8'(cw), 8'(cs_)};
      tim_cle_re = 4'(cle_d); tim_ale_re = 4'(ale_d);
      @(negedge clk);
      tim_load = 1'b0;
      m_data = '{ds, dw, dh, dz};
      m_ctl  = '{cs_, cw, ch, cz};
      m_cle = cle_d; m_ale = ale_d;
   endtask

   function automatic int one_min(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic run_cycle(input int kind, input int cs, input bit narrow,
                            input logic [15:0] wd, input logic [15:0] di, input int stall_k);
      int set[4];
      int d, s, w, h, z, total;
      bit rd, wide_eff;
      logic [15:0] mask;
      int n = 0, pre = 0, stb = 0, post = 0, ce_cnt = 0, oth = 0, wsc = 0;
      int oe_cnt = 0, cle_cnt = 0, ale_cnt = 0, rsp_cnt = 0, rsp_at = -1, dqbad = 0, left = 0;
      bit seen = 0;
      logic [15:0] rsp_data = '0;
      rd = (kind == 2);
      set = (kind >= 2) ? m_data : m_ctl;
      d = rd ? ((m_last == 0) ? m_cle : (m_last == 1) ? m_ale : 0) : 0;
      s = one_min(set[0]);
      w = one_min(set[1]) + ((m_wait && stall_k > 0) ? stall_k : 0);
      h = one_min(set[2]);
      z = rd ? 0 : set[3];
      total = d + s + w + h + z;
      wide_eff = m_wide && !narrow && (kind >= 2);
      mask = wide_eff ? 16'hFFFF : 16'h00FF;

      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(kind); req_cs = 1'(cs);
      req_narrow = narrow; req_wdata = wd; nand_dq_i = di;
      check("R2", "ready when idle and enabled", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      while (n < 2000) begin
         if (req_ready) break;
         n++;
         if ((rd ? !nand_re_n : !nand_we_n)) begin
            stb++;
            if (!rd && nand_dq_o !== (wd & mask)) dqbad++;
            if (!seen && stall_k > 0) begin nand_rb = 1'b0; left = stall_k; end
            seen = 1;
         end else if (!seen) pre++;
         else post++;
         if (rd ? !nand_we_n : !nand_re_n) wsc++;
         if (!nand_ce_n[cs]) ce_cnt++;
         if (!nand_ce_n[1-cs]) oth++;
         if (nand_dq_oe) oe_cnt++;
         if (nand_cle) cle_cnt++;
         if (nand_ale) ale_cnt++;
         if (rsp_valid) begin rsp_cnt++; rsp_at = n - 1; rsp_data = rsp_rdata; end
         @(negedge clk);
         if (left > 0) begin left--; if (left == 0) nand_rb = 1'b1; end
      end
      nand_rb = 1'b1;
      check("R3", "chip enable clocks", ce_cnt, total);
      check("R7", "other chip enable clocks", oth, 0);
      check("R8", "clocks before strobe (delay+setup)", pre, d + s);
      check("R9", "strobe low clocks", stb, w);
      check("R5", "clocks after strobe (hold+release)", post, h + z);
      check("R3", "wrong strobe clocks", wsc, 0);
      check("R5", "bus drive clocks", oe_cnt, rd ? 0 : total);
      check("R6", "cle clocks", cle_cnt, (kind == 0) ? total : 0);
      check("R6", "ale clocks", ale_cnt, (kind == 1) ? total : 0);
      if (rd) begin
         check("R10", "rsp pulses", rsp_cnt, 1);
         check("R10", "rsp clock index", rsp_at, d + s + w);
         check("R11", "read data", int'(rsp_data), int'(di & mask));
      end else begin
         check("R10", "rsp pulses on non-read", rsp_cnt, 0);
         check("R11", "driven data mismatches", dqbad, 0);
      end
      m_last = kind;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int it = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "req_ready", int'(req_ready), 0);
      check("R1", "ce_n", int'(nand_ce_n), 3);
      check("R1", "we_n/re_n", int'({nand_we_n, nand_re_n}), 3);
      check("R1", "cle/ale/oe", int'({nand_cle, nand_ale, nand_dq_oe}), 0);
      check("R1", "rsp_valid", int'(rsp_valid), 0);

      // R2 requests while bank disabled are dropped
      req_valid = 1'b1; req_kind = 2'd3;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check("R2", "ce_n while disabled", int'(nand_ce_n), 3);
         check("R2", "ready while disabled", int'(req_ready), 0);
      end
      req_valid = 1'b0;
      set_ctl(1, 0, 0);
      @(negedge clk);
      check("R2", "dropped request did not start", int'(nand_ce_n), 3);

      // R1 default timings: 10 everywhere, delays 15 (command then read)
      m_data = '{10, 10, 10, 10};
      m_ctl  = '{10, 10, 10, 10};
      run_cycle(0, 0, 0, 16'h0070, 16'h0000, 0);
      run_cycle(2, 0, 0, 16'h0000, 16'h00E5, 0);

      // R3 R4 R5 R6 R8 sweep, wide mode
      set_ctl(1, 0, 1);
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 4; w++)
            for (int h = 0; h < 3; h++)
               for (int z = 0; z < 3; z++) begin
                  set_tim(s, w, h, z, s + 2, w + 2, h + 1, z ^ 1, 2, 3);
                  for (int k = 0; k < 4; k++) begin
                     run_cycle(k, it % 2, it[2], 16'hA5C3 ^ 16'(it), 16'h3C5A + 16'(it), 0);
                     it++;
                  end
               end

      // R11 byte mode
      set_ctl(1, 0, 0);
      set_tim(1, 2, 1, 1, 1, 1, 1, 0, 1, 4);
      for (int k = 0; k < 8; k++)
         run_cycle(k % 4, k % 2, k[2], 16'hBEEF + 16'(k), 16'hF00D - 16'(k), 0);

      // R9 stall on busy
      set_ctl(1, 1, 1);
      set_tim(1, 2, 1, 1, 1, 2, 1, 1, 2, 2);
      run_cycle(3, 0, 0, 16'h1234, 16'h0, 3);
      run_cycle(0, 1, 0, 16'h0090, 16'h0, 1);
      run_cycle(2, 1, 0, 16'h0, 16'h4321, 2);
      run_cycle(1, 0, 0, 16'h0012, 16'h0, 4);
      run_cycle(2, 0, 1, 16'h0, 16'hA1B2, 1);
      // R9 busy ignored when wait mode is off
      set_ctl(1, 0, 1);
      run_cycle(3, 1, 0, 16'h5678, 16'h0, 3);
      run_cycle(2, 0, 0, 16'h0, 16'h9ABC, 2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule